// File: doc/BRIEF.md
# TDM Audio Slot Transmitter

This block puts audio samples onto one serial data line as a time-division multiplexed frame. A frame has up to sixteen slots. Each slot is either active, and then carries one sample, or inactive. The block steps one bit position for every bit-clock enable. A frame-start pulse realigns it to the first bit of slot 0. Between pulses the block wraps to slot 0 on its own once the last slot ends.

Inside an active slot the block first drives a run of leading zeros, the first-bit offset. Then it sends the sample MSB first, then pads the slot out to its full length. A tristate mode lets the block release the line, through a pad output-enable, for inactive slots and for padding that precedes an inactive slot. Samples arrive over a valid/ready handshake, one per active slot. A missing sample gives a silent slot and raises a sticky underrun flag.

The frame geometry is sampled only while `enable` is low. The block then uses it unchanged for the whole time it stays enabled.

Top module: `tdm_slot_tx`

## Requirements
- R1: A frame holds `cfg_slot_count`+1 slots, inactive ones included. After the last slot the block continues with slot 0. A `frame_start` sampled together with `bclk_en` makes the next bit time bit 0 of slot 0.
- R2: Bit i of `cfg_slot_mask` set marks slot i active. `s_ready` is high only in a cycle whose `bclk_en` edge enters bit 0 of an active slot, and the sample is taken at that edge if `s_valid` is high.
- R3: Slot length in bits follows `cfg_slot_size`: 0 gives the data size, 1 gives 16, 2 gives 32, and the reserved code 3 acts like 0. A fixed length shorter than the data size is raised to the data size.
- R4: A sample is `cfg_data_size`+1 bits wide, right-aligned in `s_data`, and is sent MSB first with one bit per bit time.
- R5: In an active slot, bit positions below `cfg_first_offset` are driven to 0 with `sd_oe` high.
- R6: When offset plus data size is more than the slot length, the slot ends on time and the remaining sample bits are dropped.
- R7: Padding after the data is driven to 0 when `cfg_tristate` is 0. When `cfg_tristate` is 1, padding is driven to 0 if the next slot is active, and released (`sd_oe` low) if the next slot is inactive. The slot after the last one is slot 0.
- R8: During an inactive slot `sd_oe` is low when `cfg_tristate` is 1, and `sd_out` is driven to 0 otherwise.
- R9: If `s_valid` is low at the fetch of an active slot, the data bits of that slot are 0 and `underrun` goes high and stays high until reset.
- R10: Configuration inputs are captured only on clock edges where `enable` is low. Changes while enabled have no effect on the line.
- R11: After an edge with `enable` low, and while no `frame_start` has arrived since enabling, `sd_oe`, `sd_out` and `s_ready` are low.
- R12: After reset `sd_oe`, `sd_out`, `s_ready` and `underrun` are 0.
- R13: `sd_out` is 0 whenever `sd_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; configuration is captured while low |
| bclk_en | input | 1 | One-cycle strobe per bit time |
| frame_start | input | 1 | Frame alignment pulse, qualified by `bclk_en` |
| cfg_slot_mask | input | 16 | Active flag for each slot position |
| cfg_slot_count | input | 4 | Slots per frame minus one |
| cfg_slot_size | input | 2 | Slot length code |
| cfg_data_size | input | 5 | Sample bits minus one |
| cfg_first_offset | input | 5 | Leading zero bits in an active slot |
| cfg_tristate | input | 1 | Release the line instead of driving idle zeros |
| s_valid | input | 1 | Sample available |
| s_data | input | 32 | Sample, right-aligned |
| s_ready | output | 1 | Sample taken this cycle when valid |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Pad output enable |
| underrun | output | 1 | Sticky missing-sample flag |

## Verification
The bench builds the block with its package defaults: sixteen slot positions and 32-bit samples. With these values the full 16-slot frame, 32-bit slots with 24-bit data, and truncation against both the 16-bit and the 32-bit slot length are all reachable. The cases combine sparse and full masks, slot codes 0 to 3, offsets up to 31, both tristate settings, bit-clock enables every cycle and every third cycle, a frame pulse in mid-frame, configuration changes while enabled, and sample starvation. A queue-based model predicts the line, its enable, the ready strobe and the underrun flag on every clock.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    parameter int unsigned MAX_SLOTS = 16;
    parameter int unsigned SAMPLE_W  = 32;
    parameter int unsigned OFF_W     = 5;

    localparam int unsigned SLOT_W = $clog2(MAX_SLOTS);
    localparam int unsigned DSZ_W  = $clog2(SAMPLE_W);
    localparam int unsigned BIT_W  = $clog2(SAMPLE_W) + 2;

    typedef enum logic [1:0] {
        SZ_DATA = 2'd0,
        SZ_16   = 2'd1,
        SZ_32   = 2'd2,
        SZ_RSVD = 2'd3
    } slot_sz_e;

    typedef enum logic [1:0] {
        PH_OFFSET,
        PH_DATA,
        PH_PAD
    } phase_e;

    typedef struct packed {
        logic [MAX_SLOTS-1:0] mask;
        logic [SLOT_W-1:0]    last_slot;
        slot_sz_e             size_sel;
        logic [DSZ_W-1:0]     dsz_m1;
        logic [OFF_W-1:0]     offset;
        logic                 tristate;
    } cfg_t;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
    } pos_t;

    function automatic logic [BIT_W-1:0] slot_bits(cfg_t c);
        logic [BIT_W-1:0] dbits;
        logic [BIT_W-1:0] fixed;
        dbits = BIT_W'(c.dsz_m1) + BIT_W'(1);
        case (c.size_sel)
            SZ_16:   fixed = BIT_W'(16);
            SZ_32:   fixed = BIT_W'(32);
            default: fixed = dbits;
        endcase
        return (fixed < dbits) ? dbits : fixed;
    endfunction

endpackage

// File: rtl/tdm_cfg_shadow.sv
module tdm_cfg_shadow
    import tdm_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  cfg_t cfg_d,
    output cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (!enable) begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq
    import tdm_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 bclk_en,
    input  logic                 frame_start,
    input  logic [MAX_SLOTS-1:0] mask,
    input  logic [SLOT_W-1:0]    last_slot,
    input  logic [BIT_W-1:0]     slot_len,
    output pos_t                 pos,
    output logic                 running,
    output logic                 adv,
    output logic                 fetch,
    output logic                 cur_active,
    output logic                 next_active
);

    pos_t              pos_q;
    pos_t              pos_n;
    logic              run_q;
    logic [SLOT_W-1:0] succ;

    always_comb begin
        succ = (pos_q.slot == last_slot) ? '0 : pos_q.slot + 1'b1;
    end

    always_comb begin
        pos_n = pos_q;
        if (frame_start) begin
            pos_n = '0;
        end else if (pos_q.bitn == slot_len - 1'b1) begin
            pos_n.bitn = '0;
            pos_n.slot = succ;
        end else begin
            pos_n.bitn = pos_q.bitn + 1'b1;
        end
    end

    always_comb begin
        adv         = enable && bclk_en && (run_q || frame_start);
        fetch       = adv && (pos_n.bitn == '0) && mask[pos_n.slot];
        cur_active  = mask[pos_q.slot];
        next_active = mask[succ];
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            run_q <= 1'b0;
            pos_q <= '0;
        end else if (adv) begin
            run_q <= 1'b1;
            pos_q <= pos_n;
        end
    end

    assign pos     = pos_q;
    assign running = run_q;

endmodule

// File: rtl/tdm_bit_shaper.sv
module tdm_bit_shaper
    import tdm_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                running,
    input  logic                adv,
    input  logic                fetch,
    input  logic [BIT_W-1:0]    bitn,
    input  logic                cur_active,
    input  logic                next_active,
    input  logic [OFF_W-1:0]    offset,
    input  logic [DSZ_W-1:0]    dsz_m1,
    input  logic                tristate,
    input  logic                s_valid,
    input  logic [SAMPLE_W-1:0] s_data,
    output logic                sd_out,
    output logic                sd_oe,
    output logic                underrun
);

    localparam logic [DSZ_W-1:0] TOP_IDX = DSZ_W'(SAMPLE_W - 1);

    logic [SAMPLE_W-1:0] sh_q;
    logic                has_q;
    logic                und_q;
    logic [BIT_W-1:0]    data_end;
    phase_e              phase;
    logic                bit_v;

    always_comb begin
        data_end = BIT_W'(offset) + BIT_W'(dsz_m1) + BIT_W'(1);
        if (bitn < BIT_W'(offset)) begin
            phase = PH_OFFSET;
        end else if (bitn < data_end) begin
            phase = PH_DATA;
        end else begin
            phase = PH_PAD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            has_q <= 1'b0;
            und_q <= 1'b0;
        end else if (fetch) begin
            has_q <= s_valid;
            sh_q  <= s_valid ? (s_data << (TOP_IDX - dsz_m1)) : '0;
            if (!s_valid) begin
                und_q <= 1'b1;
            end
        end else if (adv && phase == PH_DATA) begin
            sh_q <= sh_q << 1;
        end
    end

    always_comb begin
        sd_oe = 1'b0;
        bit_v = 1'b0;
        if (running) begin
            if (!cur_active) begin
                sd_oe = !tristate;
            end else begin
                case (phase)
                    PH_OFFSET: sd_oe = 1'b1;
                    PH_DATA: begin
                        sd_oe = 1'b1;
                        bit_v = has_q && sh_q[SAMPLE_W-1];
                    end
                    default: sd_oe = !(tristate && !next_active);
                endcase
            end
        end
        sd_out = sd_oe && bit_v;
    end

    assign underrun = und_q;

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
    import tdm_tx_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          enable,
    input  logic                          bclk_en,
    input  logic                          frame_start,
    input  logic [tdm_tx_pkg::MAX_SLOTS-1:0] cfg_slot_mask,
    input  logic [tdm_tx_pkg::SLOT_W-1:0]    cfg_slot_count,
    input  logic [1:0]                    cfg_slot_size,
    input  logic [tdm_tx_pkg::DSZ_W-1:0]     cfg_data_size,
    input  logic [tdm_tx_pkg::OFF_W-1:0]     cfg_first_offset,
    input  logic                          cfg_tristate,
    input  logic                          s_valid,
    input  logic [tdm_tx_pkg::SAMPLE_W-1:0]  s_data,
    output logic                          s_ready,
    output logic                          sd_out,
    output logic                          sd_oe,
    output logic                          underrun
);

    cfg_t             cfg_d;
    cfg_t             cfg_q;
    pos_t             pos;
    logic             running;
    logic             adv;
    logic             fetch;
    logic             cur_active;
    logic             next_active;
    logic [BIT_W-1:0] slot_len;

    always_comb begin
        cfg_d.mask      = cfg_slot_mask;
        cfg_d.last_slot = cfg_slot_count;
        cfg_d.size_sel  = slot_sz_e'(cfg_slot_size);
        cfg_d.dsz_m1    = cfg_data_size;
        cfg_d.offset    = cfg_first_offset;
        cfg_d.tristate  = cfg_tristate;
        slot_len        = slot_bits(cfg_q);
    end

    tdm_cfg_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .cfg_d  (cfg_d),
        .cfg_q  (cfg_q)
    );

    tdm_slot_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .bclk_en     (bclk_en),
        .frame_start (frame_start),
        .mask        (cfg_q.mask),
        .last_slot   (cfg_q.last_slot),
        .slot_len    (slot_len),
        .pos         (pos),
        .running     (running),
        .adv         (adv),
        .fetch       (fetch),
        .cur_active  (cur_active),
        .next_active (next_active)
    );

    tdm_bit_shaper u_shaper (
        .clk         (clk),
        .rst         (rst),
        .running     (running),
        .adv         (adv),
        .fetch       (fetch),
        .bitn        (pos.bitn),
        .cur_active  (cur_active),
        .next_active (next_active),
        .offset      (cfg_q.offset),
        .dsz_m1      (cfg_q.dsz_m1),
        .tristate    (cfg_q.tristate),
        .s_valid     (s_valid),
        .s_data      (s_data),
        .sd_out      (sd_out),
        .sd_oe       (sd_oe),
        .underrun    (underrun)
    );

    assign s_ready = fetch;

    a_r1_slot_in_frame: assert property (@(posedge clk) disable iff (rst)
        running |-> (pos.slot <= cfg_q.last_slot));

    a_r3_bit_in_slot: assert property (@(posedge clk) disable iff (rst)
        running |-> (pos.bitn < slot_len));

    a_r2_ready_on_strobe: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (enable && bclk_en));

    a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running)) |-> $stable(cfg_q));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!running && !frame_start) |-> (!sd_oe && !s_ready));

    a_r13_released_low: assert property (@(posedge clk) disable iff (rst)
        !sd_oe |-> !sd_out);

endmodule

// File: tb/tdm_slot_tx_tb_top.sv
module tdm_slot_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        bclk = 1'b0;
    logic        fs = 1'b0;
    logic [15:0] c_mask = '0;
    logic [3:0]  c_cnt = '0;
    logic [1:0]  c_sel = '0;
    logic [4:0]  c_dm1 = '0;
    logic [4:0]  c_off = '0;
    logic        c_tri = 1'b0;
    logic        s_valid = 1'b0;
    logic [31:0] s_data = '0;
    logic        s_ready;
    logic        sd_out;
    logic        sd_oe;
    logic        underrun;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit starve = 1'b0;
    int q[$];

    // behavioural reference state
    int  m_mask, m_last, m_sel, m_dbits, m_off, m_tri;
    int  m_slot, m_bit, m_samp;
    bit  m_run, m_has, m_und;

    always #5 clk = ~clk;

    tdm_slot_tx dut_i (
        .clk(clk), .rst(rst), .enable(en), .bclk_en(bclk), .frame_start(fs),
        .cfg_slot_mask(c_mask), .cfg_slot_count(c_cnt), .cfg_slot_size(c_sel),
        .cfg_data_size(c_dm1), .cfg_first_offset(c_off), .cfg_tristate(c_tri),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .sd_out(sd_out), .sd_oe(sd_oe), .underrun(underrun)
    );

    function automatic int m_len();
        int f;
        f = (m_sel == 1) ? 16 : (m_sel == 2) ? 32 : m_dbits;
        return (f < m_dbits) ? m_dbits : f;
    endfunction

    function automatic int m_succ(int s);
        return (s == m_last) ? 0 : s + 1;
    endfunction

    function automatic bit m_act(int s);
        return ((m_mask >> s) & 1) == 1;
    endfunction

    task automatic m_next(output int ns, output int nb);
        if (fs) begin
            ns = 0; nb = 0;
        end else if (m_bit + 1 >= m_len()) begin
            ns = m_succ(m_slot); nb = 0;
        end else begin
            ns = m_slot; nb = m_bit + 1;
        end
    endtask

    function automatic bit m_ready();
        int ns, nb;
        if (!(en && bclk && (m_run || fs))) return 1'b0;
        if (fs) begin ns = 0; nb = 0; end
        else if (m_bit + 1 >= m_len()) begin ns = m_succ(m_slot); nb = 0; end
        else begin ns = m_slot; nb = m_bit + 1; end
        return (nb == 0) && m_act(ns);
    endfunction

    always @(posedge clk) begin
        int ns, nb;
        bit rdy;
        if (rst) begin
            m_run = 0; m_und = 0; m_has = 0; m_slot = 0; m_bit = 0;
            m_mask = 0; m_last = 0; m_sel = 0; m_dbits = 1; m_off = 0; m_tri = 0;
        end else if (!en) begin
            m_run = 0; m_slot = 0; m_bit = 0;
            m_mask = int'(c_mask); m_last = int'(c_cnt); m_sel = int'(c_sel);
            m_dbits = int'(c_dm1) + 1; m_off = int'(c_off); m_tri = int'(c_tri);
        end else if (bclk && (m_run || fs)) begin
            rdy = m_ready();
            m_next(ns, nb);
            if (rdy) begin
                if (s_valid) begin
                    m_has = 1; m_samp = q.pop_front();
                end else begin
                    m_has = 0; m_und = 1;
                end
            end
            m_slot = ns; m_bit = nb; m_run = 1;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_line();
        bit eo, ed;
        string tag;
        int rel;
        eo = 0; ed = 0;
        if (!m_run) begin
            tag = "R11";
        end else if (!m_act(m_slot)) begin
            tag = "R8"; eo = (m_tri == 0);
        end else if (m_bit < m_off) begin
            tag = "R5"; eo = 1;
        end else if (m_bit - m_off < m_dbits) begin
            rel = m_bit - m_off;
            eo = 1;
            if (m_has) begin
                tag = (m_off + m_dbits > m_len()) ? "R6" : "R4";
                ed = ((m_samp >> (m_dbits - 1 - rel)) & 1) == 1;
            end else begin
                tag = "R9";
            end
        end else begin
            tag = "R7";
            eo = !(m_tri == 1 && !m_act(m_succ(m_slot)));
        end
        check(sd_oe == eo, tag, "sd_oe", int'(sd_oe), int'(eo));
        check(sd_out == ed, tag, "sd_out", int'(sd_out), int'(ed));
        check(!(sd_out && !sd_oe), "R13", "sd_out while released", int'(sd_out), 0);
        check(underrun == m_und, "R9", "underrun", int'(underrun), int'(m_und));
    endtask

    task automatic step(bit e, bit b, bit f);
        bit er;
        @(negedge clk);
        compare_line();
        while (q.size() < 24) q.push_back(int'($urandom));
        en = e; bclk = b; fs = f;
        s_valid = !starve && (q.size() > 0);
        s_data  = (q.size() > 0) ? 32'(q[0]) : 32'h0;
        #1;
        if (!rst) begin
            er = m_ready();
            check(s_ready == er, "R2", "s_ready", int'(s_ready), int'(er));
        end
    endtask

    task automatic run_case(input logic [15:0] mk, input int cnt, input int sel, input int dm1,
                            input int off, input bit tri_m, input int bits, input int div,
                            input int resync_at, input bit noise, input bit starving);
        int len;
        int dbits;
        c_mask = mk; c_cnt = 4'(cnt); c_sel = 2'(sel); c_dm1 = 5'(dm1); c_off = 5'(off); c_tri = tri_m;
        starve = 1'b0;
        repeat (3) step(0, 0, 0);
        // R11: enabled but no frame pulse yet
        repeat (3) step(1, 1, 0);
        dbits = dm1 + 1;
        len = (sel == 1) ? 16 : (sel == 2) ? 32 : dbits;
        if (len < dbits) len = dbits;
        for (int i = 0; i < bits * div; i++) begin
            bit b;
            bit f;
            b = (i % div) == 0;
            f = b && ((i == 0) || (resync_at > 0 && i / div == resync_at));
            starve = starving && ((i / 150) % 2 == 1);
            if (noise && i > 0) begin
                // R10: these changes must not reach the line
                c_mask = 16'($urandom); c_cnt = 4'($urandom); c_sel = 2'($urandom);
                c_dm1 = 5'($urandom); c_off = 5'($urandom); c_tri = 1'($urandom);
            end
            step(1, b, f);
        end
        starve = 1'b0;
        repeat (3) step(0, 0, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step(0, 0, 0);
        rst = 1'b0;
        step(0, 0, 0);
        // R12: reset state at the ports
        check(!sd_oe && !sd_out && !s_ready && !underrun, "R12", "reset outputs",
              int'({sd_oe, sd_out, s_ready, underrun}), 0);

        // R4 R5 R7: 4 slots, sparse mask, 16-bit slots, 12-bit data, offset 2, driven padding
        run_case(16'h000B, 3, 1, 11, 2, 1'b0, 4 * 16 * 3, 1, 0, 1'b0, 1'b0);
        // R7 R8: tristate, 8 slots, 32-bit slots, 24-bit data, offset 1
        run_case(16'h005A, 7, 2, 23, 1, 1'b1, 8 * 32 * 2, 1, 0, 1'b0, 1'b0);
        // R1 R3: slot length equals data size, 16 active 8-bit slots, slow bit clock
        run_case(16'hFFFF, 15, 0, 7, 0, 1'b1, 16 * 8 * 2, 3, 0, 1'b0, 1'b0);
        // R6: offset 5 with 16-bit data in a 16-bit slot truncates
        run_case(16'h0003, 2, 1, 15, 5, 1'b1, 3 * 16 * 3, 1, 0, 1'b0, 1'b0);
        // R3: 16-bit code with 24-bit data is raised to 24; reserved code 3
        run_case(16'h0005, 3, 1, 23, 0, 1'b0, 4 * 24 * 2, 1, 0, 1'b0, 1'b0);
        run_case(16'h0006, 3, 3, 9, 31, 1'b1, 4 * 10 * 3, 1, 0, 1'b0, 1'b0);
        // R6: offset 20 with 20-bit data in 32-bit slots
        run_case(16'h0009, 3, 2, 19, 20, 1'b1, 4 * 32 * 2, 2, 0, 1'b0, 1'b0);
        // R1: frame pulse in mid-frame realigns to slot 0; R10: config noise while enabled
        run_case(16'h0035, 5, 1, 15, 3, 1'b1, 6 * 16 * 3, 1, 37, 1'b1, 1'b0);
        // R9: starvation causes silent slots and a sticky flag
        run_case(16'h00F1, 7, 1, 13, 1, 1'b0, 8 * 16 * 4, 1, 0, 1'b0, 1'b1);

        rst = 1'b1;
        step(0, 0, 0);
        rst = 1'b0;
        step(0, 0, 0);
        check(!underrun, "R12", "underrun after reset", int'(underrun), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule